// File: doc/BRIEF.md
# Programmable Down-Counter Timer with Compare

A 32-bit periodic timer controlled through a small word-indexed register port. While enabled, a down-counter takes one step on each cycle where the tick input is high. When it leaves zero it either reloads from a load register or wraps to all-ones, depending on a mode bit. A compare register sets a sticky status flag whenever a tick moves the count onto the compare value. The flag drives the interrupt output, gated by the compare-interrupt enable.

Software programs the load and compare values and then sets the enable bit. With the enable-mode bit set, the count restarts on the 0-to-1 edge of enable. An overwrite bit lets a write to the load register take effect on the counter at once, instead of waiting for the next reload. A software-reset control bit returns the registers to their defaults and keeps only the run-related control bits. The stop, doze, wait and debug enable bits (control bits 4 to 7) are stored and read back but have no effect.

Top module: `dt_timer`

## Requirements
- R1: Register index is the byte address shifted right by two: 0 control, 1 status (flag in bit 0), 2 load, 3 compare, 4 live counter (read-only). Any other index reads 0, and writes to index 4 or above change nothing.
- R2: A control write stores only bits 25:0; bits 31:26 read 0. The software-reset bit (16) always reads 0.
- R3: A control write with bit 16 set clears status, sets load to 0xFFFFFFFF, clears compare and sets the counter to 0xFFFFFFFF. Control keeps only the written bits 0, 1, 4, 5, 6 and 7; all others are cleared.
- R4: While enable (bit 0) is set, each tick decrements the counter. A tick at zero loads the load register if reload-mode (bit 3) is set, else 0xFFFFFFFF.
- R5: A control write that takes enable from 0 to 1 with enable-mode (bit 1) set restarts the counter from load (reload-mode set) or from 0xFFFFFFFF. Rewriting control while enabled does not restart. A restart or overwrite in the same cycle as a tick takes the place of that tick's step.
- R6: With enable clear, ticks leave the counter unchanged and raise no compare event.
- R7: A load write while overwrite (bit 17) is set copies the value into the counter at once. Otherwise the counter is untouched until the next reload.
- R8: When enable and compare-interrupt enable (bit 2) are set, a tick that moves the count onto the compare value sets the status flag the next cycle. This includes a compare value of 0.
- R9: Writing 1 to status bit 0 clears the flag. A compare match in the same cycle wins, and the flag stays set.
- R10: The interrupt output equals the status flag ANDed with compare-interrupt enable.
- R11: After hardware reset: control 0, status 0, load 0xFFFFFFFF, compare 0, counter 0xFFFFFFFF, interrupt low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| we_i | input | 1 | Register write strobe |
| idx_i | input | 3 | Register index (byte address >> 2) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for idx_i, combinational |
| tick_i | input | 1 | Count enable, one step per high cycle |
| irq_o | output | 1 | Compare interrupt |

## Verification
Two events can land in one cycle: a status clear write and a tick that moves the count onto the compare value. A second pair is a load overwrite or enable restart together with a tick. The bench drives these cases on purpose: it writes status 1 on the very tick that reaches a zero compare, and it mixes random writes with random ticks. A bench model is updated in the same cycle and gives the expected result: the flag stays set, and the register write decides the counter value.

// File: rtl/dt_pkg.sv
package dt_pkg;
  localparam int unsigned CTRL_W = 26;
  localparam int unsigned IDX_W  = 3;

  localparam int unsigned B_EN   = 0;
  localparam int unsigned B_MODE = 1;
  localparam int unsigned B_CIE  = 2;
  localparam int unsigned B_RLD  = 3;
  localparam int unsigned B_SWR  = 16;
  localparam int unsigned B_OVW  = 17;

  // enable, enable-mode, and the four stored power/debug bits survive soft reset
  localparam logic [CTRL_W-1:0] KEEP_MASK = 26'h00000F3;

  typedef enum logic [IDX_W-1:0] {
    IDX_CTRL = 3'd0,
    IDX_STAT = 3'd1,
    IDX_LOAD = 3'd2,
    IDX_CMP  = 3'd3,
    IDX_CNT  = 3'd4
  } reg_idx_e;
endpackage

// File: rtl/dt_regs.sv
module dt_regs
  import dt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [CTRL_W-1:0] ctrl_o,
  output logic [DW-1:0]     load_o,
  output logic [DW-1:0]     cmp_o,
  output logic              soft_rst_o,
  output logic              stat_clr_o,
  output logic              cnt_ld_o,
  output logic [DW-1:0]     cnt_ld_val_o
);
  logic              ctrl_wr, load_wr, cmp_wr, swr, en_rise, ovw_wr;
  logic [CTRL_W-1:0] wv, ctrl_nx, ctrl_q;
  logic [DW-1:0]     load_q, cmp_q;

  assign ctrl_wr = we_i && (idx_i == IDX_CTRL);
  assign load_wr = we_i && (idx_i == IDX_LOAD);
  assign cmp_wr  = we_i && (idx_i == IDX_CMP);
  assign wv      = wdata_i[CTRL_W-1:0];
  assign swr     = ctrl_wr && wv[B_SWR];

  always_comb begin
    ctrl_nx        = wv;
    ctrl_nx[B_SWR] = 1'b0;
    if (swr) ctrl_nx = wv & KEEP_MASK;
  end

  assign en_rise = ctrl_wr && !swr && ctrl_nx[B_EN] && !ctrl_q[B_EN] && ctrl_nx[B_MODE];
  assign ovw_wr  = load_wr && ctrl_q[B_OVW];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      load_q <= '1;
      cmp_q  <= '0;
    end else begin
      if (ctrl_wr) ctrl_q <= ctrl_nx;
      if (swr) begin
        load_q <= '1;
        cmp_q  <= '0;
      end
      if (load_wr) load_q <= wdata_i;
      if (cmp_wr)  cmp_q  <= wdata_i;
    end
  end

  always_comb begin
    cnt_ld_val_o = wdata_i;
    if (swr)          cnt_ld_val_o = '1;
    else if (en_rise) cnt_ld_val_o = ctrl_nx[B_RLD] ? load_q : '1;
  end

  assign cnt_ld_o   = swr || en_rise || ovw_wr;
  assign soft_rst_o = swr;
  assign stat_clr_o = we_i && (idx_i == IDX_STAT) && wdata_i[0];
  assign ctrl_o     = ctrl_q;
  assign load_o     = load_q;
  assign cmp_o      = cmp_q;

  AST_SWR_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr |=> (load_q == '1) && (cmp_q == '0)); // R3
  AST_SWR_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swr |=> ((ctrl_q & ~KEEP_MASK) == '0)); // R3
  AST_SWR_NOT_STORED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr |=> !ctrl_q[B_SWR]); // R2
endmodule

// File: rtl/dt_counter.sv
module dt_counter #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          rld_i,
  input  logic          tick_i,
  input  logic          ld_i,
  input  logic [DW-1:0] ld_val_i,
  input  logic [DW-1:0] load_i,
  output logic [DW-1:0] cnt_o,
  output logic          step_o,
  output logic [DW-1:0] nxt_o
);
  logic [DW-1:0] cnt_q;

  assign step_o = run_i && tick_i && !ld_i;
  assign nxt_o  = (cnt_q == '0) ? (rld_i ? load_i : '1) : cnt_q - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '1;
    else if (ld_i)   cnt_q <= ld_val_i;
    else if (step_o) cnt_q <= nxt_o;
  end

  assign cnt_o = cnt_q;

  AST_DECREMENT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !ld_i && cnt_q != '0) |=> cnt_q == $past(cnt_q) - 1'b1); // R4
  AST_FREE_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (run_i && tick_i && !ld_i && cnt_q == '0 && !rld_i) |=> cnt_q == '1); // R4
  AST_HOLD_STOPPED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !ld_i) |=> $stable(cnt_q)); // R6
endmodule

// File: rtl/dt_match.sv
module dt_match #(
  parameter int unsigned DW = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          step_i,
  input  logic [DW-1:0] nxt_i,
  input  logic [DW-1:0] cmp_i,
  input  logic          cie_i,
  input  logic          clr_i,
  input  logic          srst_i,
  output logic          flag_o,
  output logic          irq_o
);
  logic hit, flag_q;

  assign hit = step_i && cie_i && (nxt_i == cmp_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     flag_q <= 1'b0;
    else if (srst_i) flag_q <= 1'b0;
    else if (hit)    flag_q <= 1'b1;  // match beats a same-cycle clear
    else if (clr_i)  flag_q <= 1'b0;
  end

  assign flag_o = flag_q;
  assign irq_o  = flag_q && cie_i;

  AST_HIT_SETS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> flag_q); // R8
  AST_FLAG_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(flag_q) |-> $past(hit)); // R8
  AST_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !hit) |=> !flag_q); // R9
  AST_IRQ_MASK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cie_i |-> !irq_o); // R10
endmodule

// File: rtl/dt_timer.sv
module dt_timer
  import dt_pkg::*;
#(
  parameter int unsigned DW = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [DW-1:0]    wdata_i,
  output logic [DW-1:0]    rdata_o,
  input  logic             tick_i,
  output logic             irq_o
);
  localparam int unsigned PAD_W = DW - CTRL_W;

  logic [CTRL_W-1:0] ctrl;
  logic [DW-1:0]     load, cmp, cnt, ld_val, nxt;
  logic              soft_rst, stat_clr, cnt_ld, step, flag;

  dt_regs #(.DW(DW)) u_regs (
    .clk_i, .rst_ni, .we_i, .idx_i, .wdata_i,
    .ctrl_o(ctrl), .load_o(load), .cmp_o(cmp),
    .soft_rst_o(soft_rst), .stat_clr_o(stat_clr),
    .cnt_ld_o(cnt_ld), .cnt_ld_val_o(ld_val)
  );

  dt_counter #(.DW(DW)) u_cnt (
    .clk_i, .rst_ni,
    .run_i(ctrl[B_EN]), .rld_i(ctrl[B_RLD]), .tick_i,
    .ld_i(cnt_ld), .ld_val_i(ld_val), .load_i(load),
    .cnt_o(cnt), .step_o(step), .nxt_o(nxt)
  );

  dt_match #(.DW(DW)) u_match (
    .clk_i, .rst_ni,
    .step_i(step), .nxt_i(nxt), .cmp_i(cmp), .cie_i(ctrl[B_CIE]),
    .clr_i(stat_clr), .srst_i(soft_rst),
    .flag_o(flag), .irq_o
  );

  always_comb begin
    unique case (idx_i)
      IDX_CTRL: rdata_o = {{PAD_W{1'b0}}, ctrl};
      IDX_STAT: rdata_o = {{(DW-1){1'b0}}, flag};
      IDX_LOAD: rdata_o = load;
      IDX_CMP:  rdata_o = cmp;
      IDX_CNT:  rdata_o = cnt;
      default:  rdata_o = '0;
    endcase
  end

  AST_CNT_RO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (we_i && idx_i == IDX_CNT && !tick_i) |=> $stable(cnt)); // R1
endmodule

// File: tb/dt_timer_test.sv
module dt_timer_test;
  logic        clk = 1'b0, rst_ni = 1'b0, we = 1'b0, tick = 1'b0;
  logic [2:0]  idx = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        irq;
  int total = 0, bad = 0;

  always #5 clk = ~clk;  // 10 units per period: 100 MHz at 1 ns

  dt_timer #(.DW(32)) uut (
    .clk_i(clk), .rst_ni(rst_ni), .we_i(we), .idx_i(idx), .wdata_i(wdata),
    .rdata_o(rdata), .tick_i(tick), .irq_o(irq)
  );

  // bench model
  logic [25:0] m_ctrl, n_ctrl;
  logic        m_stat, n_stat;
  logic [31:0] m_load, m_cmp, m_cnt, n_load, n_cmp, n_cnt;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input logic [2:0] i, output logic [31:0] v);
    idx = i;
    #1;
    v = rdata;
  endtask

  task automatic exp_rd(input logic [2:0] i, input logic [31:0] e, input string tag);
    logic [31:0] v;
    rd(i, v);
    chk(tag, v, e);
  endtask

  task automatic check_all(string tag);
    exp_rd(3'd0, {6'd0, m_ctrl}, {tag, " ctrl R2"});
    exp_rd(3'd1, {31'd0, m_stat}, {tag, " stat R8"});
    exp_rd(3'd2, m_load, {tag, " load R7"});
    exp_rd(3'd3, m_cmp, {tag, " cmp R1"});
    exp_rd(3'd4, m_cnt, {tag, " cnt R4"});
    chk({tag, " irq R10"}, {31'd0, irq}, {31'd0, m_stat & m_ctrl[2]});
  endtask

  task automatic model_step(bit w, logic [2:0] i, logic [31:0] d, bit t);
    bit ld = 0, hit = 0, clr = 0, srst = 0;
    logic [31:0] ldv = '0, nx;
    n_ctrl = m_ctrl; n_stat = m_stat; n_load = m_load; n_cmp = m_cmp; n_cnt = m_cnt;
    if (w) begin
      case (i)
        3'd0: begin
          n_ctrl = d[25:0];
          if (n_ctrl[16]) begin
            srst = 1; n_ctrl = n_ctrl & 26'h00000F3;
            ld = 1; ldv = '1; n_load = '1; n_cmp = '0;
          end else if (n_ctrl[0] && !m_ctrl[0] && n_ctrl[1]) begin
            ld = 1; ldv = n_ctrl[3] ? m_load : '1;
          end
          n_ctrl[16] = 1'b0;
        end
        3'd1: clr = d[0];
        3'd2: begin n_load = d; if (m_ctrl[17]) begin ld = 1; ldv = d; end end
        3'd3: n_cmp = d;
        default: ;
      endcase
    end
    if (ld) n_cnt = ldv;
    else if (m_ctrl[0] && t) begin
      nx = (m_cnt == 0) ? (m_ctrl[3] ? m_load : 32'hFFFF_FFFF) : m_cnt - 1;
      hit = m_ctrl[2] && (nx == m_cmp);
      n_cnt = nx;
    end
    if (srst) n_stat = 0;
    else if (hit) n_stat = 1;
    else if (clr) n_stat = 0;
  endtask

  task automatic do_cycle(bit w, logic [2:0] i, logic [31:0] d, bit t);
    @(negedge clk);
    we = w; idx = i; wdata = d; tick = t;
    model_step(w, i, d, t);
    @(posedge clk);
    #1;
    m_ctrl = n_ctrl; m_stat = n_stat; m_load = n_load; m_cmp = n_cmp; m_cnt = n_cnt;
    we = 0; tick = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog expired");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int unsigned seed_v;
    logic [31:0] d;
    m_ctrl = '0; m_stat = 0; m_load = '1; m_cmp = '0; m_cnt = '1;
    seed_v = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    // R11 reset state
    exp_rd(3'd0, 32'h0, "R11 ctrl");
    exp_rd(3'd1, 32'h0, "R11 stat");
    exp_rd(3'd2, 32'hFFFF_FFFF, "R11 load");
    exp_rd(3'd3, 32'h0, "R11 cmp");
    exp_rd(3'd4, 32'hFFFF_FFFF, "R11 cnt");
    chk("R11 irq", {31'd0, irq}, 32'd0);

    // zero compare, reload mode
    do_cycle(1, 3'd2, 32'd3, 0);
    exp_rd(3'd4, 32'hFFFF_FFFF, "R7 no overwrite");
    do_cycle(1, 3'd3, 32'd0, 0);
    do_cycle(1, 3'd0, 32'h0000_000F, 0);
    exp_rd(3'd4, 32'd3, "R5 restart from load");
    repeat (3) do_cycle(0, 3'd0, 32'd0, 1);
    exp_rd(3'd4, 32'd0, "R4 decrement");
    exp_rd(3'd1, 32'd1, "R8 compare at zero");
    chk("R10 irq high", {31'd0, irq}, 32'd1);
    do_cycle(1, 3'd1, 32'd1, 0);
    exp_rd(3'd1, 32'd0, "R9 clear");
    do_cycle(0, 3'd0, 32'd0, 1);
    exp_rd(3'd4, 32'd3, "R4 reload");
    repeat (2) do_cycle(0, 3'd0, 32'd0, 1);
    do_cycle(1, 3'd1, 32'd1, 1);
    exp_rd(3'd1, 32'd1, "R9 match beats clear");
    do_cycle(1, 3'd1, 32'd1, 0);
    // compare enable off: no flag
    do_cycle(1, 3'd0, 32'h0000_000B, 0);
    exp_rd(3'd4, 32'd0, "R5 no restart when enabled");
    repeat (4) do_cycle(0, 3'd0, 32'd0, 1);
    exp_rd(3'd1, 32'd0, "R8 masked compare");
    // disabled: hold
    do_cycle(1, 3'd0, 32'h0000_0008, 0);
    do_cycle(0, 3'd0, 32'd0, 1);
    exp_rd(3'd4, 32'd0, "R6 hold when disabled");
    // free-run, overwrite
    do_cycle(1, 3'd0, 32'h0002_0003, 0);
    exp_rd(3'd4, 32'hFFFF_FFFF, "R5 restart free-run");
    do_cycle(1, 3'd2, 32'd2, 1);
    exp_rd(3'd4, 32'd2, "R7 overwrite beats tick");
    repeat (3) do_cycle(0, 3'd0, 32'd0, 1);
    exp_rd(3'd4, 32'hFFFF_FFFF, "R4 wrap to ones");
    do_cycle(1, 3'd0, 32'h0000_000B, 0);
    do_cycle(1, 3'd2, 32'd9, 0);
    exp_rd(3'd4, 32'hFFFF_FFFF, "R7 deferred load");
    do_cycle(1, 3'd0, 32'h0000_0000, 0);
    do_cycle(1, 3'd0, 32'h0000_000B, 0);
    exp_rd(3'd4, 32'd9, "R5 restart uses new load");
    // soft reset
    do_cycle(1, 3'd3, 32'd5, 0);
    do_cycle(1, 3'd0, 32'h0001_00FF, 0);
    exp_rd(3'd0, 32'h0000_00F3, "R3 kept bits");
    exp_rd(3'd2, 32'hFFFF_FFFF, "R3 load default");
    exp_rd(3'd3, 32'h0, "R3 cmp cleared");
    exp_rd(3'd4, 32'hFFFF_FFFF, "R3 counter");
    // index map
    exp_rd(3'd5, 32'h0, "R1 unmapped read");
    do_cycle(1, 3'd4, 32'd0, 0);
    exp_rd(3'd4, 32'hFFFF_FFFF, "R1 counter read-only");
    do_cycle(1, 3'd0, 32'hFC02_00F0, 0);
    exp_rd(3'd0, 32'h0002_00F0, "R2 low 26 bits");
    check_all("directed");

    // random mix
    for (int n = 0; n < 4000; n++) begin
      int unsigned op;
      bit t;
      op = $urandom_range(9);
      t  = ($urandom_range(3) != 0);
      case (op)
        6: begin
          d = $urandom & 32'hFC03_00FF;
          if ($urandom_range(31) != 0) d[16] = 1'b0;
          if ($urandom_range(3) != 0) d[0] = 1'b1;
          if ($urandom_range(1) != 0) d[3] = 1'b1;
          do_cycle(1, 3'd0, d, t);
        end
        7: do_cycle(1, 3'd1, $urandom, t);
        8: do_cycle(1, 3'd2, $urandom_range(12), t);
        9: do_cycle(1, 3'd3, $urandom_range(12), t);
        default: do_cycle(0, 3'd0, 32'd0, t);
      endcase
      check_all("random");
    end
    if (seed_v == 32'hFFFF_FFFF) $display("seed wrap");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule